// File: doc/BRIEF.md
# Configurable Port Logic Array

This block turns each group of four I/O ports into a small programmable gate. In each group the first three ports can serve as gate inputs and the fourth port carries the result. For every input port, a select bit chooses the source of the gate input: either the already synchronized pin level or a value supplied by an external debouncer. Each group has its own 8-bit configuration register. That register picks the gate type (AND, OR or XOR), which two of the three input ports form the pair, the polarity of each input, and whether the remaining port joins as a third input.

The gate result goes straight to the output port as combinational logic. A per-group selector chooses between the gate result and the ordinary GPIO drive value. Any configuration code the encoding does not define returns the group to GPIO drive, so a bad write can never produce an undefined gate. The number of groups is a parameter. Two groups is the default.

Top module: `cla_port_array`

## Requirements
- R1: After reset every configuration register reads as 0x00, so every group is in GPIO mode: `port_out[g]` equals `gpio_out[g]` and `arr_active[g]` is 0.
- R2: When `cfg_we[g]` is 1 at a rising clock edge, group g's register loads `cfg_wdata`. A group whose write enable is 0 keeps its code.
- R3: Bits [7:6] of the code choose the gate: 01 = AND, 10 = OR, 11 = XOR. The value 00 means GPIO mode.
- R4: Bits [5:4] of the code choose the input pair, using port indices local to the group (group g port k is input bit g*3+k): 00 = ports 0 and 1, 01 = ports 0 and 2, 10 = ports 1 and 2.
- R5: Bit 3 of the code inverts the first port of the pair and bit 2 inverts the second, before the gate.
- R6: When bit 1 of the code is 1, the port not in the pair becomes a third gate input with the same gate type, and bit 0 inverts it.
- R7: A code with pair field 11, or with bit 1 = 0 and bit 0 = 1, is undefined. It behaves like gate field 00: the group drives `gpio_out` and `arr_active` is 0.
- R8: When `arr_sel[g]` is 0, `port_out[g]` equals `gpio_out[g]` and `arr_active[g]` is 0, whatever the code.
- R9: Gate input k of a group takes its value from `pin_deb` when the matching `in_sel` bit is 1, and from `pin_sync` when it is 0.
- R10: The gate result reaches `port_out` with no register on the path, so it follows an input change before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_sync | input | NUM_GRP*3 | Synchronized levels of the input-capable ports |
| pin_deb | input | NUM_GRP*3 | Debounced levels of the same ports |
| in_sel | input | NUM_GRP*3 | Per-port source select, 1 = debounced |
| cfg_we | input | NUM_GRP | Per-group configuration write enable |
| cfg_wdata | input | 8 | Configuration code to write |
| arr_sel | input | NUM_GRP | Per-group output port select, 1 = logic array |
| gpio_out | input | NUM_GRP | Ordinary GPIO drive value for each output port |
| port_out | output | NUM_GRP | Value driven onto each group's output port |
| arr_active | output | NUM_GRP | Group is driving a gate result |

## Verification
The corner that is hardest to reach from the ports is the set of undefined codes that differ from a valid code by one bit: an inversion bit for the third input while the third input is disabled, and the reserved pair field. The stimulus writes such codes into one group while the other group holds a valid gate. It then sweeps all eight input combinations, so that a decoder that wrongly accepts the code shows up as a gate-shaped output instead of the GPIO value. Each result is sampled mid-cycle, before the next clock edge, which also shows that no register lies on the path.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CFG_W = 8;
  localparam int IN_PER_GRP = 3;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XOR  = 2'b11
  } cla_op_e;

  typedef enum logic [1:0] {
    PAIR_01  = 2'b00,
    PAIR_02  = 2'b01,
    PAIR_12  = 2'b10,
    PAIR_RSV = 2'b11
  } cla_pair_e;

  typedef struct packed {
    cla_op_e   op;     // [7:6]
    cla_pair_e pair;   // [5:4]
    logic      inv_a;  // [3]
    logic      inv_b;  // [2]
    logic      three;  // [1]
    logic      inv_c;  // [0]
  } cla_cfg_t;
endpackage

// File: rtl/cla_rst_sync.sv
module cla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cla_cfg_reg.sv
module cla_cfg_reg
  import cla_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  cla_cfg_t wdata,
  output cla_cfg_t cfg_q
);
  cla_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R2: a write lands on the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == $past(wdata)));
  // R2: no write, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/cla_in_mux.sv
module cla_in_mux #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] raw_val,
  input  logic [WIDTH-1:0] deb_val,
  input  logic [WIDTH-1:0] use_deb,
  output logic [WIDTH-1:0] sel_val
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb sel_val[i] = use_deb[i] ? deb_val[i] : raw_val[i];
  end
endmodule

// File: rtl/cla_gate.sv
module cla_gate
  import cla_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  cla_cfg_t              cfg,
  input  logic [IN_PER_GRP-1:0] ins,
  input  logic                  arr_sel,
  input  logic                  gpio,
  output logic                  port_out,
  output logic                  active
);
  logic code_ok;
  logic in_a, in_b, in_c;
  logic op_a, op_b, op_c;
  logic result;

  always_comb begin
    code_ok = (cfg.op != OP_NONE) && (cfg.pair != PAIR_RSV) &&
              (cfg.three || !cfg.inv_c);
  end

  always_comb begin
    unique case (cfg.pair)
      PAIR_02: begin in_a = ins[0]; in_b = ins[2]; in_c = ins[1]; end
      PAIR_12: begin in_a = ins[1]; in_b = ins[2]; in_c = ins[0]; end
      default: begin in_a = ins[0]; in_b = ins[1]; in_c = ins[2]; end
    endcase
    op_a = in_a ^ cfg.inv_a;
    op_b = in_b ^ cfg.inv_b;
    op_c = in_c ^ cfg.inv_c;
  end

  always_comb begin
    unique case (cfg.op)
      OP_AND:  result = op_a & op_b & (op_c | !cfg.three);
      OP_OR:   result = op_a | op_b | (op_c & cfg.three);
      OP_XOR:  result = op_a ^ op_b ^ (op_c & cfg.three);
      default: result = 1'b0;
    endcase
  end

  always_comb begin
    active   = arr_sel && code_ok;
    port_out = active ? result : gpio;
  end

  // R8: selector off means plain GPIO drive
  a_r8_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_sel |-> (port_out == gpio) && !active);
  // R7: reserved pair field falls back to GPIO
  a_r7_rsv_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pair == PAIR_RSV) |-> !active && (port_out == gpio));
  // R7: third-input inversion without third input is undefined
  a_r7_stray_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.three && cfg.inv_c) |-> !active && (port_out == gpio));
  // R3: plain two-input AND on ports 0 and 1
  a_r3_and01: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg.op == OP_AND && cfg.pair == PAIR_01 && !cfg.three &&
     !cfg.inv_a && !cfg.inv_b) |-> (port_out == (ins[0] & ins[1])));
  // R6: three-input XOR is the parity of the inputs and inversions
  a_r6_xor3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg.op == OP_XOR && cfg.three) |->
      (port_out == (^ins ^ cfg.inv_a ^ cfg.inv_b ^ cfg.inv_c)));
endmodule

// File: rtl/cla_port_array.sv
module cla_port_array
  import cla_pkg::*;
#(
  parameter int NUM_GRP = 2,
  localparam int NIN = NUM_GRP * IN_PER_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NIN-1:0]     pin_sync,
  input  logic [NIN-1:0]     pin_deb,
  input  logic [NIN-1:0]     in_sel,
  input  logic [NUM_GRP-1:0] cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [NUM_GRP-1:0] arr_sel,
  input  logic [NUM_GRP-1:0] gpio_out,
  output logic [NUM_GRP-1:0] port_out,
  output logic [NUM_GRP-1:0] arr_active
);
  logic rst_n_s;
  logic [NIN-1:0] gate_in;

  cla_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cla_in_mux #(.WIDTH(NIN)) u_in_mux (
    .raw_val (pin_sync),
    .deb_val (pin_deb),
    .use_deb (in_sel),
    .sel_val (gate_in)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cla_cfg_t cfg_q;

    cla_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n_s),
      .we    (cfg_we[g]),
      .wdata (cla_cfg_t'(cfg_wdata)),
      .cfg_q (cfg_q)
    );

    cla_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .cfg      (cfg_q),
      .ins      (gate_in[g*IN_PER_GRP +: IN_PER_GRP]),
      .arr_sel  (arr_sel[g]),
      .gpio     (gpio_out[g]),
      .port_out (port_out[g]),
      .active   (arr_active[g])
    );
  end
endmodule

// File: tb/cla_port_array_bench.sv
module cla_port_array_bench;
  localparam int NG  = 2;
  localparam int NIN = NG * 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NIN-1:0]  pin_sync, pin_deb, in_sel;
  logic [NG-1:0]   cfg_we, arr_sel, gpio_out;
  logic [7:0]      cfg_wdata;
  logic [NG-1:0]   port_out, arr_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] cfg_sh [NG];
  logic [2*NG-1:0] exp_q[$];
  string rq_q[$];
  event ev_drv;

  always #5 clk = ~clk;

  cla_port_array #(.NUM_GRP(NG)) u_cla_port_array (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pin_deb(pin_deb),
    .in_sel(in_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .arr_sel(arr_sel), .gpio_out(gpio_out), .port_out(port_out),
    .arr_active(arr_active)
  );

  // Expected {active, out} from the code encoding in the requirements
  function automatic logic [1:0] model(logic [7:0] c, logic [2:0] v,
                                       logic sel, logic gpio);
    logic a, b, x, r, ok;
    ok = (c[7:6] != 2'b00) && (c[5:4] != 2'b11) && !(!c[1] && c[0]);
    case (c[5:4])
      2'b01:   begin a = v[0]; b = v[2]; x = v[1]; end
      2'b10:   begin a = v[1]; b = v[2]; x = v[0]; end
      default: begin a = v[0]; b = v[1]; x = v[2]; end
    endcase
    a = a ^ c[3]; b = b ^ c[2]; x = x ^ c[0];
    case (c[7:6])
      2'b01:   r = c[1] ? (a & b & x) : (a & b);
      2'b10:   r = c[1] ? (a | b | x) : (a | b);
      default: r = c[1] ? (a ^ b ^ x) : (a ^ b);
    endcase
    if (sel && ok) return {1'b1, r};
    return {1'b0, gpio};
  endfunction

  task automatic wr_cfg(int g, logic [7:0] d);
    @(negedge clk);
    cfg_we = '0; cfg_we[g] = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = '0;
    cfg_sh[g] = d;
  endtask

  // Driver: set inputs at a falling edge, push expected results
  task automatic apply(string rq, logic [NIN-1:0] ps, logic [NIN-1:0] pd,
                       logic [NIN-1:0] is, logic [NG-1:0] as,
                       logic [NG-1:0] go);
    logic [2*NG-1:0] e;
    @(negedge clk);
    pin_sync = ps; pin_deb = pd; in_sel = is; arr_sel = as; gpio_out = go;
    for (int g = 0; g < NG; g++) begin
      logic [2:0] v;
      logic [1:0] m;
      for (int k = 0; k < 3; k++)
        v[k] = is[g*3+k] ? pd[g*3+k] : ps[g*3+k];
      m = model(cfg_sh[g], v, as[g], go[g]);
      e[g] = m[0]; e[NG+g] = m[1];
    end
    exp_q.push_back(e);
    rq_q.push_back(rq);
    -> ev_drv;
  endtask

  // Monitor: compare mid-cycle, before the next rising edge (R10)
  initial begin
    forever begin
      @(ev_drv);
      #2;
      while (exp_q.size() > 0) begin
        logic [2*NG-1:0] e;
        string rq;
        e = exp_q.pop_front();
        rq = rq_q.pop_front();
        checks++;
        if ({arr_active, port_out} !== e) begin
          errors++;
          $display("FAIL %s: active/out=%b/%b expected %b/%b", rq,
                   arr_active, port_out, e[2*NG-1:NG], e[NG-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [12];
    string      tags  [12];
    codes[0]  = 8'h40; tags[0]  = "R3 and01";
    codes[1]  = 8'h80; tags[1]  = "R3 or01";
    codes[2]  = 8'hC0; tags[2]  = "R3 xor01";
    codes[3]  = 8'h4C; tags[3]  = "R5 and both inverted";
    codes[4]  = 8'h48; tags[4]  = "R5 and first inverted";
    codes[5]  = 8'h54; tags[5]  = "R4 and02 second inverted";
    codes[6]  = 8'hA0; tags[6]  = "R4 or12";
    codes[7]  = 8'h42; tags[7]  = "R6 and3";
    codes[8]  = 8'hC3; tags[8]  = "R6 xor3 third inverted";
    codes[9]  = 8'h91; tags[9]  = "R7 stray inversion";
    codes[10] = 8'h70; tags[10] = "R7 reserved pair";
    codes[11] = 8'h00; tags[11] = "R7 gate none";

    for (int g = 0; g < NG; g++) cfg_sh[g] = 8'h00;
    rst_n = 1'b0; pin_sync = '0; pin_deb = '0; in_sel = '0;
    cfg_we = '0; cfg_wdata = '0; arr_sel = '0; gpio_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset leaves both groups in GPIO mode
    apply("R1 reset gpio", 6'b111111, '0, '0, 2'b11, 2'b10);
    apply("R1 reset gpio", 6'b011011, '0, '0, 2'b11, 2'b01);

    // R2: write one group only, the other keeps its code
    wr_cfg(0, 8'h40);
    apply("R2 write g0 only", 6'b011011, '0, '0, 2'b11, 2'b10);
    apply("R2 write g0 only", 6'b000011, '0, '0, 2'b11, 2'b00);

    // R3..R7 with R10 sampling: sweep codes over all input patterns
    for (int ci = 0; ci < 12; ci++) begin
      wr_cfg(0, codes[ci]);
      wr_cfg(1, codes[11 - ci]);
      for (int v = 0; v < 8; v++) begin
        logic [2:0] vv;
        vv = 3'(v);
        apply(tags[ci], {~vv, vv}, '0, '0, 2'b11, 2'(v));
      end
    end

    // R8: selector off with valid gates
    wr_cfg(0, 8'hC0);
    wr_cfg(1, 8'h80);
    apply("R8 selector off", 6'b001010, '0, '0, 2'b00, 2'b00);
    apply("R8 selector off", 6'b010001, '0, '0, 2'b00, 2'b11);
    apply("R8 selector mixed", 6'b010001, '0, '0, 2'b01, 2'b10);

    // R9: debounced vs synchronized source per port
    apply("R9 all raw", 6'b000001, 6'b000011, 6'b000000, 2'b11, 2'b00);
    apply("R9 deb on port1", 6'b000001, 6'b000011, 6'b000010, 2'b11, 2'b00);
    apply("R9 deb on port0", 6'b000001, 6'b000011, 6'b000001, 2'b11, 2'b00);
    apply("R9 group1 deb", 6'b000000, 6'b010000, 6'b010000, 2'b11, 2'b00);

    // R10: consecutive input changes with no edge in between
    @(negedge clk);
    pin_sync = 6'b000001; in_sel = '0; arr_sel = 2'b11; gpio_out = '0;
    #1;
    pin_sync = 6'b000011;
    #1;
    checks++;
    if (port_out[0] !== 1'b0) begin
      errors++;
      $display("FAIL R10 same-cycle: out=%b expected 0", port_out[0]);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule